// File: doc/BRIEF.md
# Serial Memory Read Target on a Two-Wire Bus

This block is the target side of an I2C link that serves reads from a 512-byte array. Each transaction opens with an address byte. Its high nibble must carry the device code. One bit of it holds the top memory address bit, and its lowest bit gives the direction. A write-direction transaction carries one further byte, the low eight address bits, and it only loads the internal address counter. Read-direction transactions stream bytes starting at the counter. The controller acknowledges each byte to ask for the next one, and a missing acknowledge ends the stream.

The bus lines are sampled in the system clock domain. The block reports its bus drive as a single pull-low enable, so the line is the controller's level ANDed with the inverse of that enable. A separate load port fills the array before or between transactions. Random reads work in the usual way: a write-direction header sets the address, then a repeated START with a read-direction header begins the stream.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: An address byte whose bits 7..4 differ from 1010 is not acknowledged, and the block leaves SDA released until the next START.
- R2: When bits 7..4 of the address byte are 1010, the block pulls SDA low during the ninth SCL pulse. It does the same for the word address byte that follows a write-direction header.
- R3: A write-direction header (bit 0 = 0) followed by a word address byte sets the counter. Bit 1 of the header becomes address bit 8 and the word byte becomes bits 7..0. No data moves.
- R4: A repeated START and a read-direction header (bit 0 = 1) after the R3 sequence return the byte at the loaded address first, sent most significant bit first.
- R5: After each byte sent, a controller ACK (SDA low in the ninth pulse) makes the block send the byte at the next address.
- R6: A controller NACK (SDA high in the ninth pulse) ends the stream, and SDA stays released for any further SCL pulses until a START.
- R7: The counter steps once per sent byte across all nine bits and wraps from 511 to 0 without a break in the data.
- R8: A read that has no address phase starts at the counter value the previous operation left behind, including the step for its last byte.
- R9: The SDA drive enable changes only while SCL is low.
- R10: An SDA fall while SCL is high starts a new header at bit 0 from any point. An SDA rise while SCL is high releases SDA and returns to idle.
- R11: Bits 3..2 of the address byte have no effect on acknowledge or data.
- R12: After reset, SDA is released and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock level, synchronous to clk |
| sda_in | input | 1 | Resolved bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| ld_we | input | 1 | Array load strobe |
| ld_addr | input | 9 | Array load address |
| ld_data | input | 8 | Array load data |

## Verification
The assertions assume that SCL and SDA are already synchronous to clk. They also assume that each SCL level lasts at least two clk cycles and that the controller changes SDA only while SCL is low, except to form a START or a STOP. The stimulus holds each bus phase for four clk cycles. It drives every input on the falling clk edge and changes SDA with SCL high only inside its START and STOP routines. Random start addresses and burst lengths are drawn from a fixed seed, and directed runs cover the wrap, a bad device code, a NACK and an aborted header.

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd #(
  parameter int          ADDR_W   = 9,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_DACK = 3'd2,
                         S_WORD = 3'd3, S_WACK = 3'd4, S_RD = 3'd5, S_RACK = 3'd6;

  logic [7:0]        mem [DEPTH];
  logic              scl_q, sda_q;
  logic [2:0]        state;
  logic [3:0]        bitcnt;
  logic [7:0]        sh;
  logic              rw, mack;
  logic [HI_W-1:0]   hi;
  logic [ADDR_W-1:0] addr;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda_in;
  wire stop_c   = scl & scl_q & ~sda_q & sda_in;
  wire [7:0] rd_byte = mem[addr];

  always_ff @(posedge clk)
    if (ld_we) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      state  <= S_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      hi     <= '0;
      addr   <= '0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda_in;
      if (start_c) begin
        state  <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_WORD: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_in};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == S_DEV) begin
                if (sh[7:4] == DEV_CODE) begin
                  rw     <= sh[0];
                  hi     <= sh[HI_W:1];
                  sda_oe <= 1'b1;
                  state  <= S_DACK;
                end else begin
                  state  <= S_IDLE;
                end
              end else begin
                addr   <= {hi, sh};
                sda_oe <= 1'b1;
                state  <= S_WACK;
              end
            end
          end
          S_DACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sda_oe <= ~rd_byte[7];
                sh     <= {rd_byte[6:0], 1'b0};
                state  <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_WORD;
              end
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_IDLE;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                addr   <= addr + 1'b1;
                state  <= S_RACK;
              end else begin
                sda_oe <= ~sh[7];
                sh     <= {sh[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_in;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                sda_oe <= ~rd_byte[7];
                sh     <= {rd_byte[6:0], 1'b0};
                state  <= S_RD;
              end else begin
                state  <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module i2c_eeprom_rd_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl,
  input logic              sda_oe,
  input logic              start_c,
  input logic              stop_c,
  input logic [2:0]        state,
  input logic [3:0]        bitcnt,
  input logic [ADDR_W-1:0] addr
);
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && state == 3'd0));

  assert_start_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (bitcnt == 4'd0 && state == 3'd1));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && $past(state) == 3'd5) |-> addr == ADDR_W'($past(addr) + 1'b1));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe);

  assert_dev_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && $past(state) == 3'd1) |-> sda_oe);
endmodule

bind i2c_eeprom_rd i2c_eeprom_rd_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe),
  .start_c(start_c), .stop_c(stop_c), .state(state),
  .bitcnt(bitcnt), .addr(addr)
);

// File: tb/i2c_eeprom_rd_test.sv
module i2c_eeprom_rd_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       ld_we = 1'b0;
  logic [8:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic       sda_oe;
  wire        line = sda_m & ~sda_oe;

  int         checks = 0, errors = 0, r9_bad = 0;
  logic [7:0] ref_mem [512];
  logic [8:0] exp_ptr = '0;
  logic       oe_prev = 1'b0, scl_prev = 1'b1;

  always #4 clk = ~clk;

  i2c_eeprom_rd uut (
    .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda_in(line), .sda_oe(sda_oe),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_prev) r9_bad++;
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  function automatic logic [7:0] dev_byte(input logic a8, input logic rd, input logic [1:0] junk);
    return {4'b1010, junk, a8, rd};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic bstart();
    scl_m = 1'b0; half(); sda_m = 1'b1; half();
    scl_m = 1'b1; half(); sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bstop();
    scl_m = 1'b0; sda_m = 1'b0; half();
    scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    end
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    ackd = ~line;
    scl_m = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] b, input logic ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl_m = 1'b1; half(); b[i] = line; scl_m = 1'b0;
    end
    sda_m = ack ? 1'b0 : 1'b1; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
  endtask

  task automatic rd_stream(input string tag, input int n);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rbyte(b, k != n - 1);
      chk(tag, b, ref_mem[exp_ptr]);
      exp_ptr = exp_ptr + 9'd1;
    end
  endtask

  task automatic set_addr(input logic [8:0] a, input logic [1:0] junk);
    logic ackd;
    bstart();
    wbyte(dev_byte(a[8], 1'b0, junk), ackd); chk("R2 header ack", ackd, 1);
    wbyte(a[7:0], ackd);                     chk("R2 word ack", ackd, 1);
    exp_ptr = a;
  endtask

  task automatic rand_read(input string tag, input logic [8:0] a, input int n);
    logic ackd;
    set_addr(a, 2'($urandom));
    bstart();
    wbyte(dev_byte(1'($urandom), 1'b1, 2'($urandom)), ackd);
    chk("R2 read header ack", ackd, 1);
    rd_stream(tag, n);
    bstop();
  endtask

  task automatic cur_read(input string tag, input int n, input logic [1:0] junk);
    logic ackd;
    bstart();
    wbyte(dev_byte(1'($urandom), 1'b1, junk), ackd);
    chk("R11 header ack", ackd, 1);
    rd_stream(tag, n);
    bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ackd;
    logic [7:0] b;
    int seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 512; i++) begin
      ref_mem[i] = 8'($urandom);
      ld_we = 1'b1; ld_addr = 9'(i); ld_data = ref_mem[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    half();
    chk("R12 sda released after reset", sda_oe, 0);

    exp_ptr = '0;
    cur_read("R12 R8 counter zero after reset", 2, 2'b00);

    rand_read("R4 random read", 9'h123, 1);
    rand_read("R5 sequential ack", 9'h0F0, 5);
    cur_read("R8 continue from counter", 3, 2'b11);
    rand_read("R7 wrap 511 to 0", 9'h1FE, 5);

    set_addr(9'h1A5, 2'b01);
    bstop();
    cur_read("R3 address-only write", 2, 2'b10);

    bstart();
    wbyte(8'hB1, ackd);
    chk("R1 wrong code no ack", ackd, 0);
    seen = 0;
    rbyte(b, 1'b0);
    chk("R1 bus stays released", b, 8'hFF);
    bstop();

    rand_read("R6 nack then", 9'h040, 2);
    bstart();
    wbyte(dev_byte(1'b0, 1'b1, 2'b00), ackd);
    rd_stream("R6 stream before nack", 1);
    rbyte(b, 1'b0);
    chk("R6 no drive after nack", b, 8'hFF);
    bstop();

    bstart();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    end
    rand_read("R10 start restarts header", 9'h077, 2);

    for (int t = 0; t < 20; t++) begin
      if ($urandom % 3 == 0) cur_read("R8 random current read", 1 + int'($urandom % 4), 2'($urandom));
      else rand_read("R5 random burst", 9'($urandom), 1 + int'($urandom % 6));
    end

    chk("R9 drive changes only with SCL low", r9_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule